// File: doc/BRIEF.md
# Synchronous Serial Master on a USART Engine

This block turns a USART-style shift engine into a synchronous serial master of the SPI kind. It divides the system clock by a 12-bit programmable value to make the serial clock. It shifts an 8-bit frame out on the data-out line, most significant bit first, and shifts the same number of bits in from the data-in line. Two mode bits choose the clock idle level (polarity) and whether data is sampled on the leading or the trailing clock edge (phase). Together they give the four usual SPI modes.

Software drives the block through a small register bus. It writes the divider, then the mode bits, then a transmit byte, which starts a frame. It then polls a status word for the busy and done flags and reads the received byte. Each data bit is changed on one serial clock edge and sampled on the opposite edge, so it has half a serial period to settle. Changing the mode bits while a frame is in flight spoils that frame in both directions. Slave select, interrupts and deeper buffering are not part of the block.

Top module: `usart_spi_master`

## Requirements
- R1: After reset, every register reads 0, the serial clock is 0 and data-out is 0.
- R2: Address 0 holds the divider N in bits 11:0 and reads back all 12 bits. While a frame runs, each serial clock half-period lasts exactly N+1 system clocks, so the serial rate is fclk/(2(N+1)).
- R3: Address 1 holds phase in bit 0 and polarity in bit 1, and reads back only those two bits. While no frame runs, the serial clock sits at the polarity level.
- R4: Data-out carries the transmit byte most significant bit first. Bits change only on setup edges and are sampled on sample edges. The sample edge is the leading edge (the first toggle away from idle) when phase is 0, and the trailing edge when phase is 1.
- R5: Data-in is captured on each sample edge, most significant bit first. The received byte reads at address 2 once the frame ends and stays unchanged through register writes until a later frame completes.
- R6: A write to address 2 while idle starts a frame. Status bit 0 (busy) is then high for exactly 16(N+1) system clocks, starting on the cycle after the write, during which the serial clock toggles exactly 16 times.
- R7: Status bit 1 (done) is 0 while a frame runs and is 1 after the frame ends.
- R8: A write to address 2 while busy is ignored: the running frame is unaltered and no new frame follows it.
- R9: With phase 0, the first data bit is on data-out before the leading edge, so the leading edge samples bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address (0 divider, 1 mode, 2 data, 3 status) |
| bus_wdata | input | 12 | Write data |
| bus_rdata | output | 12 | Read data for the addressed register (combinational) |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
All four modes are swept against several divider values, and each combination carries several byte patterns, including all-zeros and all-ones. A mismatched mode would show as a shifted or inverted captured byte. A divider error would show as wrong half-period and busy lengths. A bus-side slave model drives data-in only on setup edges and captures data-out only on sample edges, so a design that mixes up the two edges reads back a corrupted byte. A transmit write issued mid-frame shows whether a busy write is really ignored.

// File: rtl/spim_pkg.sv
package spim_pkg;
    localparam int unsigned SPIM_DIV_W  = 12;
    localparam int unsigned SPIM_DATA_W = 8;

    typedef enum logic [1:0] {
        REG_DIV  = 2'd0,
        REG_MODE = 2'd1,
        REG_DATA = 2'd2,
        REG_STAT = 2'd3
    } spim_reg_e;
endpackage

// File: rtl/spim_regs.sv
module spim_regs
    import spim_pkg::*;
#(
    parameter int unsigned DIV_W  = SPIM_DIV_W,
    parameter int unsigned DATA_W = SPIM_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [1:0]        addr_i,
    input  logic [DIV_W-1:0]  wdata_i,
    output logic [DIV_W-1:0]  rdata_o,
    input  logic              busy_i,
    input  logic              done_i,
    input  logic [DATA_W-1:0] rx_i,
    output logic [DIV_W-1:0]  div_o,
    output logic              pol_o,
    output logic              pha_o,
    output logic              start_o,
    output logic [DATA_W-1:0] tx_o
);
    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic             pol;
        logic             pha;
    } cfg_t;

    cfg_t      cfg_d, cfg_q;
    spim_reg_e sel;

    assign sel = spim_reg_e'(addr_i);

    always_comb begin
        cfg_d = cfg_q;
        if (wr_i && sel == REG_DIV) begin
            cfg_d.div = wdata_i;
        end
        if (wr_i && sel == REG_MODE) begin
            cfg_d.pol = wdata_i[1];
            cfg_d.pha = wdata_i[0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    always_comb begin
        unique case (sel)
            REG_DIV:  rdata_o = cfg_q.div;
            REG_MODE: rdata_o = {{(DIV_W-2){1'b0}}, cfg_q.pol, cfg_q.pha};
            REG_DATA: rdata_o = DIV_W'(rx_i);
            default:  rdata_o = {{(DIV_W-2){1'b0}}, done_i, busy_i};
        endcase
    end

    assign div_o   = cfg_q.div;
    assign pol_o   = cfg_q.pol;
    assign pha_o   = cfg_q.pha;
    assign start_o = wr_i && (sel == REG_DATA) && !busy_i;
    assign tx_o    = wdata_i[DATA_W-1:0];

    // divider only moves on a write to its own address
    assert_div_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_i && sel == REG_DIV) |=> $stable(cfg_q.div));
endmodule

// File: rtl/spim_baud.sv
module spim_baud #(
    parameter int unsigned DIV_W = spim_pkg::SPIM_DIV_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);
    logic [DIV_W-1:0] cnt_d, cnt_q;

    assign tick_o = run_i && (cnt_q >= div_i);

    always_comb begin
        if (!run_i || tick_o) cnt_d = '0;
        else                  cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assert_cnt_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> cnt_q == '0);
    assert_idle_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> cnt_q == '0);
endmodule

// File: rtl/spim_shift.sv
module spim_shift #(
    parameter int unsigned DATA_W = spim_pkg::SPIM_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [DATA_W-1:0] tx_i,
    input  logic              pol_i,
    input  logic              pha_i,
    input  logic              tick_i,
    input  logic              miso_i,
    output logic              sck_o,
    output logic              mosi_o,
    output logic              busy_o,
    output logic              done_o,
    output logic [DATA_W-1:0] rx_o
);
    localparam int unsigned EDGES = 2 * DATA_W;
    localparam int unsigned CNT_W = $clog2(EDGES);

    typedef struct packed {
        logic              busy;
        logic              done;
        logic              sck;
        logic              mosi;
        logic [CNT_W-1:0]  ecnt;
        logic [DATA_W-1:0] tx_sh;
        logic [DATA_W-1:0] rx_sh;
        logic [DATA_W-1:0] rx_data;
    } sh_t;

    sh_t  sh_d, sh_q;
    logic lead, samp;

    assign lead = ~sh_q.ecnt[0];
    assign samp = pha_i ? ~lead : lead;

    always_comb begin
        sh_d = sh_q;
        if (!sh_q.busy) begin
            sh_d.sck = pol_i;
            if (start_i) begin
                sh_d.busy  = 1'b1;
                sh_d.done  = 1'b0;
                sh_d.ecnt  = '0;
                sh_d.rx_sh = '0;
                if (!pha_i) begin
                    sh_d.mosi  = tx_i[DATA_W-1];
                    sh_d.tx_sh = tx_i << 1;
                end else begin
                    sh_d.tx_sh = tx_i;
                end
            end
        end else if (tick_i) begin
            sh_d.sck = ~sh_q.sck;
            if (samp) begin
                sh_d.rx_sh = {sh_q.rx_sh[DATA_W-2:0], miso_i};
            end else begin
                sh_d.mosi  = sh_q.tx_sh[DATA_W-1];
                sh_d.tx_sh = sh_q.tx_sh << 1;
            end
            if (sh_q.ecnt == CNT_W'(EDGES - 1)) begin
                sh_d.busy    = 1'b0;
                sh_d.done    = 1'b1;
                sh_d.ecnt    = '0;
                sh_d.rx_data = sh_d.rx_sh;
            end else begin
                sh_d.ecnt = sh_q.ecnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign sck_o  = sh_q.sck;
    assign mosi_o = sh_q.mosi;
    assign busy_o = sh_q.busy;
    assign done_o = sh_q.done;
    assign rx_o   = sh_q.rx_data;

    assert_start_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> !sh_q.busy);
    assert_frame_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sh_q.busy) |-> $past(sh_q.ecnt) == CNT_W'(EDGES - 1));
    assert_frame_clean_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sh_q.busy) |-> sh_q.ecnt == '0);
    assert_done_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sh_q.busy) |-> !sh_q.done);
    assert_done_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sh_q.busy) |-> sh_q.done);
    assert_sck_steady_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_q.busy && !tick_i) |=> $stable(sh_q.sck));
    assert_rx_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !sh_q.busy |=> $stable(sh_q.rx_data));
endmodule

// File: rtl/usart_spi_master.sv
module usart_spi_master
    import spim_pkg::*;
#(
    parameter int unsigned DIV_W  = SPIM_DIV_W,
    parameter int unsigned DATA_W = SPIM_DATA_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic [1:0]       bus_addr,
    input  logic [DIV_W-1:0] bus_wdata,
    output logic [DIV_W-1:0] bus_rdata,
    output logic             sck,
    output logic             mosi,
    input  logic             miso
);
    logic [DIV_W-1:0]  div;
    logic              pol, pha, start, tick, busy, done;
    logic [DATA_W-1:0] tx_byte, rx_byte;

    spim_regs #(.DIV_W(DIV_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_i(bus_wr), .addr_i(bus_addr),
        .wdata_i(bus_wdata), .rdata_o(bus_rdata), .busy_i(busy),
        .done_i(done), .rx_i(rx_byte), .div_o(div), .pol_o(pol),
        .pha_o(pha), .start_o(start), .tx_o(tx_byte)
    );

    spim_baud #(.DIV_W(DIV_W)) u_baud (
        .clk(clk), .rst_n(rst_n), .run_i(busy), .div_i(div), .tick_o(tick)
    );

    spim_shift #(.DATA_W(DATA_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .start_i(start), .tx_i(tx_byte),
        .pol_i(pol), .pha_i(pha), .tick_i(tick), .miso_i(miso),
        .sck_o(sck), .mosi_o(mosi), .busy_o(busy), .done_o(done),
        .rx_o(rx_byte)
    );

    assert_idle_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && $past(!busy) && $stable(pol)) |-> sck == pol);
endmodule

// File: tb/test_usart_spi_master.sv
module test_usart_spi_master;
    localparam int CLK_PERIOD = 10;
    localparam int DIV_W  = 12;
    localparam int DATA_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             bus_wr = 1'b0;
    logic [1:0]       bus_addr = 2'd0;
    logic [DIV_W-1:0] bus_wdata = '0;
    logic [DIV_W-1:0] bus_rdata;
    logic             sck, mosi;
    logic             miso = 1'b0;

    int n_cmp = 0;
    int n_bad = 0;

    usart_spi_master #(.DIV_W(DIV_W), .DATA_W(DATA_W)) i_usart_spi_master (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sck(sck),
        .mosi(mosi), .miso(miso)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // slave model and edge monitor
    bit         active = 1'b0;
    bit         cur_pha = 1'b0;
    bit         got_first = 1'b0;
    logic       first_bit = 1'b0;
    int         edge_k = 0;
    int         clk_cnt = 0;
    int         last_clk = 0;
    int         bad_half = 0;
    int         half_exp = 1;
    logic [7:0] cap = '0;
    logic [7:0] sl_sh = '0;

    always @(posedge clk) clk_cnt = clk_cnt + 1;

    always @(sck) begin : mon
        bit lead, samp;
        if (active) begin
            if (edge_k > 0 && (clk_cnt - last_clk) != half_exp) bad_half++;
            last_clk = clk_cnt;
            lead = (edge_k % 2) == 0;
            samp = cur_pha ? !lead : lead;
            if (samp) begin
                cap = {cap[6:0], mosi};
                if (!got_first) begin first_bit = mosi; got_first = 1'b1; end
            end else begin
                miso  = sl_sh[7];
                sl_sh = {sl_sh[6:0], 1'b0};
            end
            edge_k++;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [DIV_W-1:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 2'd3;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [DIV_W-1:0] v);
        @(negedge clk);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    task automatic run_frame(input logic [1:0] mode, input int div,
                             input logic [7:0] tx, input logic [7:0] sl,
                             input bit probe);
        logic [DIV_W-1:0] v;
        int  cnt;
        bit  fin;
        bus_write(2'd0, DIV_W'(div));
        bus_write(2'd1, DIV_W'(mode));
        @(negedge clk);
        chk("R3 idle sck level", 32'(sck), 32'(mode[1]));
        cur_pha = mode[0]; edge_k = 0; cap = '0; got_first = 1'b0;
        bad_half = 0; half_exp = div + 1;
        if (!mode[0]) begin miso = sl[7]; sl_sh = sl << 1; end
        else          begin sl_sh = sl; end
        active = 1'b1;
        bus_write(2'd2, DIV_W'(tx));
        #1;
        chk("R7 done low in frame", 32'(bus_rdata[1]), 32'd0);
        cnt = 0; fin = 1'b0;
        while (!fin && cnt < 70000) begin
            if (bus_addr == 2'd2) cnt++;
            else if (bus_rdata[0]) cnt++;
            else fin = 1'b1;
            if (!fin) begin
                @(negedge clk);
                bus_wr = 1'b0; bus_addr = 2'd3;
                if (probe && cnt == 4) begin
                    bus_wr = 1'b1; bus_addr = 2'd2; bus_wdata = DIV_W'(~tx);
                end
                #1;
            end
        end
        chk("R6 busy length", 32'(cnt), 32'(16 * (div + 1)));
        chk("R6 sck edge count", 32'(edge_k), 32'd16);
        chk("R7 done after frame", 32'(bus_rdata[1]), 32'd1);
        chk("R2 half period", 32'(bad_half), 32'd0);
        chk("R4 data-out byte", 32'(cap), 32'(tx));
        chk("R9 first sampled bit", 32'(first_bit), 32'(tx[7]));
        chk("R3 sck back at idle", 32'(sck), 32'(mode[1]));
        bus_read(2'd2, v);
        chk("R5 received byte", 32'(v), 32'(sl));
        if (probe) begin
            repeat (8) @(negedge clk);
            bus_read(2'd3, v);
            chk("R8 no restart after busy write", 32'(v[0]), 32'd0);
            chk("R8 no extra edges", 32'(edge_k), 32'd16);
        end
        active = 1'b0;
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 200000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : main
        logic [DIV_W-1:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            bus_read(2'(a), v);
            chk("R1 reset register", 32'(v), 32'd0);
        end
        chk("R1 reset sck", 32'(sck), 32'd0);
        chk("R1 reset data-out", 32'(mosi), 32'd0);

        // R2 / R3 readback
        bus_write(2'd0, 12'hFFF);
        bus_read(2'd0, v);
        chk("R2 divider readback", 32'(v), 32'hFFF);
        bus_write(2'd1, 12'hFFE);
        bus_read(2'd1, v);
        chk("R3 mode readback", 32'(v), 32'h2);
        @(negedge clk);
        chk("R3 idle high", 32'(sck), 32'd1);

        // sweep: modes x dividers x byte patterns
        for (int m = 0; m < 4; m++) begin
            for (int di = 0; di < 3; di++) begin
                for (int p = 0; p < 3; p++) begin
                    logic [7:0] tx, sl;
                    tx = 8'(8'h5A + p * 91 + m * 17 + di * 3);
                    sl = 8'((tx * 13) ^ 8'hC3);
                    run_frame(2'(m), di * (di + 1), tx, sl, (p == 1 && di == 1));
                end
            end
            run_frame(2'(m), 1, 8'h00, 8'hFF, 1'b0);
            run_frame(2'(m), 0, 8'hFF, 8'h00, 1'b0);
        end

        // R5 received byte held across register writes
        run_frame(2'd1, 3, 8'h96, 8'h3B, 1'b0);
        bus_write(2'd0, 12'd7);
        bus_write(2'd1, 12'd2);
        bus_read(2'd2, v);
        chk("R5 received byte held", 32'(v), 32'h3B);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule